// File: doc/BRIEF.md
# Programmable Self-Synchronizing Bit Scrambler and Descrambler

This block whitens a serial bit stream before it goes onto a line and restores it at the far end. The transmit side takes one data bit on each valid strobe and emits one scrambled bit. The receive side takes line bits and gives back the original data. Both sides keep a 10-bit history of line bits. Which history bits feed the XOR is chosen at run time by a 10-bit polynomial word. With a suitable word, the one register gives maximal-length sequences of any degree from 2 to 10. Some examples: 0x003 gives degree 2, 0x006 degree 3, 0x00C degree 4, 0x014 degree 5, 0x030 degree 6, 0x060 degree 7, 0x08E degree 8, 0x110 degree 9 and 0x240 degree 10.

The receive side is the feed-forward inverse of the transmit side, so it needs no preamble and no alignment with the transmitter. After a line error, or when the two ends start from different histories, its output is correct again once ten line bits have passed. Each direction can be bypassed on its own. While in bypass the history keeps shifting, so leaving bypass needs no resynchronization step. The usual stream breaks up long runs of identical line bits. Both ends must use the same polynomial word.

Top module: `scrambler_pair`

## Requirements
- R1: On a transmit strobe, the line bit is the data bit XOR the parity of (history AND poly). Poly bit k selects the line bit sent k+1 strobes earlier, and bit 0 is the most recent. The line bit then enters the history.
- R2: On a receive strobe, the output bit is the received bit XOR the parity of (receive history AND poly), with the same bit mapping as R1. The received bit, not the output bit, enters the receive history.
- R3: Each output valid goes high exactly one clock after its input strobe, and low one clock after a cycle with no strobe. The output bit changes in that same clock.
- R4: Without a strobe, the output bit of that direction holds its value and the history does not advance.
- R5: With tx_bypass high, the line bit equals the data bit, and that line bit still enters the transmit history.
- R6: With rx_bypass high, the output bit equals the received bit, and the received bit still enters the receive history.
- R7: A poly word of zero makes both directions pass bits through unchanged.
- R8: The receive side is self-synchronizing. When it is fed the line stream of a matching transmitter with any starting history, every output from the 11th received bit onward equals the transmitter's data. After a single line bit error, the output is correct again from the 11th bit after the error.
- R9: After reset, both output valids and both output bits are 0. The transmit history is all ones and the receive history is all zeros.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| poly | input | 10 | Feedback tap word shared by both directions |
| tx_bypass | input | 1 | Transmit pass-through |
| tx_valid | input | 1 | Transmit data strobe |
| tx_bit | input | 1 | Transmit data bit |
| tx_out_valid | output | 1 | Line bit valid |
| tx_out_bit | output | 1 | Scrambled line bit |
| rx_bypass | input | 1 | Receive pass-through |
| rx_valid | input | 1 | Received bit strobe |
| rx_bit | input | 1 | Received line bit |
| rx_out_valid | output | 1 | Recovered bit valid |
| rx_out_bit | output | 1 | Recovered data bit |

## Verification
The assertions assume that poly and the bypass inputs are stable whenever a strobe is present. They also assume that every input is at a known level from reset onward. The stimulus changes poly and the bypass controls only at the clock's falling edge, in cycles that are separate from the data pattern, and it drives every input from time zero. The strobes follow an irregular pattern with gaps, so the hold behaviour is checked alongside the shifting.

// File: rtl/scrambler_pair.sv
module scrambler_pair #(
  parameter int W = 10,
  parameter logic [W-1:0] TX_SEED = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] poly,
  input  logic         tx_bypass,
  input  logic         tx_valid,
  input  logic         tx_bit,
  output logic         tx_out_valid,
  output logic         tx_out_bit,
  input  logic         rx_bypass,
  input  logic         rx_valid,
  input  logic         rx_bit,
  output logic         rx_out_valid,
  output logic         rx_out_bit
);

  logic [W-1:0] tx_hist, rx_hist;

  wire tx_fb   = ^(tx_hist & poly);
  wire tx_line = tx_bypass ? tx_bit : (tx_bit ^ tx_fb);
  wire rx_fb   = ^(rx_hist & poly);
  wire rx_data = rx_bypass ? rx_bit : (rx_bit ^ rx_fb);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_hist      <= TX_SEED;
      tx_out_valid <= 1'b0;
      tx_out_bit   <= 1'b0;
    end else begin
      tx_out_valid <= tx_valid;
      if (tx_valid) begin
        tx_hist    <= {tx_hist[W-2:0], tx_line};
        tx_out_bit <= tx_line;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_hist      <= '0;
      rx_out_valid <= 1'b0;
      rx_out_bit   <= 1'b0;
    end else begin
      rx_out_valid <= rx_valid;
      if (rx_valid) begin
        rx_hist    <= {rx_hist[W-2:0], rx_bit};
        rx_out_bit <= rx_data;
      end
    end
  end

  a_r1_line_enters_history: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |=> tx_hist[0] == tx_out_bit);
  a_r2_received_enters_history: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> rx_hist[0] == $past(rx_bit));
  a_r3_tx_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |=> tx_out_valid);
  a_r3_tx_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_valid |=> !tx_out_valid);
  a_r3_rx_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> rx_out_valid);
  a_r4_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_valid |=> $stable(tx_out_bit) && $stable(tx_hist));
  a_r4_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> $stable(rx_out_bit) && $stable(rx_hist));
  a_r5_tx_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_bypass |=> tx_out_bit == $past(tx_bit));
  a_r6_rx_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_bypass |=> rx_out_bit == $past(rx_bit));
  a_r7_zero_poly: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && poly == '0 |=> tx_out_bit == $past(tx_bit));

endmodule

// File: tb/sim_scrambler_pair.sv
module sim_scrambler_pair;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic [9:0] poly = 10'h00C;
  logic tx_bypass = 0, tx_valid = 0, tx_bit = 0;
  logic rx_bypass = 0, rx_valid = 0, rx_bit = 0;
  logic tx_out_valid, tx_out_bit, rx_out_valid, rx_out_bit;

  int errors = 0, checks = 0;
  bit txh[$], rxh[$], remh[$];
  bit exp_txv, exp_txb, exp_rxv, exp_rxb;
  int unsigned lcg = 32'h1234_5678;
  string req;

  always #(CLK_PERIOD/2) clk = ~clk;

  scrambler_pair u0 (.clk, .rst_n, .poly, .tx_bypass, .tx_valid, .tx_bit,
    .tx_out_valid, .tx_out_bit, .rx_bypass, .rx_valid, .rx_bit,
    .rx_out_valid, .rx_out_bit);

  function automatic bit par(bit q[$], logic [9:0] p);
    bit r = 0;
    for (int k = 0; k < 10; k++) if (p[k]) r ^= q[k];
    return r;
  endfunction

  function automatic bit rnd();
    lcg = lcg * 1103515245 + 12345;
    return lcg[16];
  endfunction

  task automatic check(string r, string what, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b", r, what, act, exp);
    end
  endtask

  // called at a falling edge; outputs compared at the next falling edge
  task automatic step(bit tv, bit tb, bit rv, bit rb);
    bit o;
    tx_valid = tv; tx_bit = tb; rx_valid = rv; rx_bit = rb;
    exp_txv = tv; exp_rxv = rv;
    if (tv) begin
      o = tx_bypass ? tb : (tb ^ par(txh, poly));
      exp_txb = o;
      txh.push_front(o); void'(txh.pop_back());
    end
    if (rv) begin
      exp_rxb = rx_bypass ? rb : (rb ^ par(rxh, poly));
      rxh.push_front(rb); void'(rxh.pop_back());
    end
    @(negedge clk);
    check(req, "tx_out_valid", tx_out_valid, exp_txv);
    check(req, "tx_out_bit",   tx_out_bit,   exp_txb);
    check(req, "rx_out_valid", rx_out_valid, exp_rxv);
    check(req, "rx_out_bit",   rx_out_bit,   exp_rxb);
  endtask

  // remote transmitter model feeding the receive side
  task automatic remote_run(int n, int err_at, logic [9:0] start, string tag);
    bit d, line;
    for (int k = 0; k < 10; k++) remh[k] = start[k];
    for (int i = 0; i < n; i++) begin
      d = rnd();
      line = d ^ par(remh, poly);
      remh.push_front(line); void'(remh.pop_back());
      if (i == err_at) line = ~line;
      step(0, 0, 1, line);
      if (i >= 10 && !(err_at >= 0 && i >= err_at && i <= err_at + 10))
        check(tag, "recovered data", rx_out_bit, d);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [9:0] polys [9] = '{10'h003, 10'h006, 10'h00C, 10'h014, 10'h030,
                              10'h060, 10'h08E, 10'h110, 10'h240};
    for (int k = 0; k < 10; k++) begin txh.push_back(1); rxh.push_back(0); remh.push_back(0); end
    repeat (3) @(negedge clk);
    check("R9", "tx_out_valid", tx_out_valid, 0);
    check("R9", "tx_out_bit", tx_out_bit, 0);
    check("R9", "rx_out_valid", rx_out_valid, 0);
    check("R9", "rx_out_bit", rx_out_bit, 0);
    rst_n = 1;
    exp_txv = 0; exp_txb = 0; exp_rxv = 0; exp_rxb = 0;
    // R9: first strobe after reset reveals tx seed (all ones) and rx zero history
    req = "R9"; step(1, 0, 1, 0);
    req = "R1"; for (int i = 0; i < 200; i++) step(rnd(), rnd(), rnd(), rnd());
    req = "R4"; for (int i = 0; i < 20; i++) step(0, rnd(), 0, rnd());
    req = "R1"; for (int i = 0; i < 40; i++) step(1, 0, 1, 0);
    req = "R3"; for (int i = 0; i < 60; i++) step(i % 3 == 0, rnd(), i % 2 == 0, rnd());
    tx_bypass = 1; req = "R5";
    for (int i = 0; i < 40; i++) step(rnd(), rnd(), rnd(), rnd());
    tx_bypass = 0; req = "R5";
    for (int i = 0; i < 40; i++) step(1, rnd(), 1, rnd());
    rx_bypass = 1; req = "R6";
    for (int i = 0; i < 40; i++) step(rnd(), rnd(), 1, rnd());
    rx_bypass = 0; req = "R6";
    for (int i = 0; i < 40; i++) step(1, rnd(), 1, rnd());
    poly = 10'h000; req = "R7";
    for (int i = 0; i < 40; i++) step(1, rnd(), 1, rnd());
    foreach (polys[j]) begin
      poly = polys[j]; req = "R2";
      for (int i = 0; i < 60; i++) step(rnd(), rnd(), rnd(), rnd());
    end
    poly = 10'h240; req = "R8";
    remote_run(80, -1, 10'h2A5, "R8");
    remote_run(80, 30, 10'h1C3, "R8");
    poly = 10'h08E;
    remote_run(60, 25, 10'h3FF, "R8");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule